// File: doc/BRIEF.md
# Speculative Load Address Table

This block is a small fully associative table that records loads issued ahead of possibly conflicting stores. Each entry holds a register tag, which is a register type plus a register number, and also a physical byte address and an access size. A later check load asks whether its register tag is still present. A hit means that no conflicting store came in between, so the speculative value can be kept. A miss makes the check logic redo the load.

The table changes in response to these commands:

- Load writes allocate or update entries.
- Store addresses remove every entry whose byte range overlaps the store.
- A register-invalidate command removes the entry for one tag.
- A flush empties the table.
- A register-frame change notification with a nonzero delta also empties the table.

A miss is always a safe answer. A hit is never reported for a tag that is absent.

Top module: `spec_load_table`

## Requirements
- R1: After reset, or while rst_ni is low, every entry is invalid and every lookup returns 0.
- R2: chk_hit_o is 1 exactly when a valid entry holds the tag {chk_rtype_i, chk_rnum_i}. Register type is part of the tag.
- R3: A write to a tag that is already present updates that entry's address and size, and no second entry is created. A write to a new tag takes the lowest-index free entry.
- R4: When no entry matches and all entries are valid, the write replaces the entry selected by a round-robin pointer. The pointer starts at entry 0 and advances by one after each replacement.
- R5: A write with wr_ldtype_i 0 (advanced) or 1 (check, no clear) is applied. Values 2 and 3 change nothing.
- R6: An address invalidate clears every valid entry where entry_addr < req_addr + req_bytes and req_addr < entry_addr + entry_bytes. A size code s in 0..4 means 2^s bytes, and codes 5..7 mean 16 bytes. Ranges that only touch are not cleared.
- R7: A register invalidate clears only the entry with the matching tag. All other entries are kept.
- R8: A flush clears every entry.
- R9: A frame notification with a nonzero bottom or size delta clears every entry. With both deltas zero it has no effect.
- R10: If an invalidate and a write occur in the same cycle, the invalidate applies first. The written entry is then valid.
- R11: A lookup sees the table as it was at the start of its cycle. A command takes effect only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Load write command |
| wr_ldtype_i | input | 2 | Load type: 0 advanced, 1 check no-clear, 2/3 no write |
| wr_rtype_i | input | RT_W | Register type of write |
| wr_rnum_i | input | RN_W | Register number of write |
| wr_addr_i | input | ADDR_W | Physical address of write |
| wr_size_i | input | 3 | Size code of write |
| chk_rtype_i | input | RT_W | Lookup register type |
| chk_rnum_i | input | RN_W | Lookup register number |
| chk_hit_o | output | 1 | Lookup hit |
| ainv_valid_i | input | 1 | Address invalidate command |
| ainv_addr_i | input | ADDR_W | Store physical address |
| ainv_size_i | input | 3 | Store size code |
| rinv_valid_i | input | 1 | Register invalidate command |
| rinv_rtype_i | input | RT_W | Register type to invalidate |
| rinv_rnum_i | input | RN_W | Register number to invalidate |
| flush_i | input | 1 | Clear whole table |
| frame_valid_i | input | 1 | Register frame change notification |
| frame_dbof_i | input | DELTA_W | Bottom-of-frame delta |
| frame_dsof_i | input | DELTA_W | Size-of-frame delta |

## Verification
The lookup result is combinational from the entry registers. It is due in the same cycle as the query and reflects only commands applied at earlier edges. Each command applies at the next rising edge, and its effect appears in a lookup made in the following cycle. The bench drives every command and lookup at the falling edge and reads chk_hit_o one nanosecond later, before the rising edge that applies the command. A check of a command's effect is therefore always placed in the next vector or directed step. Vectors that carry a write and a check of the same tag confirm that the old state is still seen in the write's own cycle.

// File: rtl/slt_pkg.sv
`timescale 1ns/1ps
package slt_pkg;
  typedef enum logic [1:0] {
    LD_ADV     = 2'd0,
    LD_CHK_NC  = 2'd1,
    LD_CHK_CLR = 2'd2,
    LD_RSVD    = 2'd3
  } ld_kind_e;

  localparam int unsigned SZ_W    = 3;
  localparam int unsigned BYTES_W = 5;

  // size code to byte count; codes above 4 saturate at 16
  function automatic logic [BYTES_W-1:0] sz_bytes(input logic [SZ_W-1:0] code);
    return (code >= 3'd4) ? 5'd16 : (5'd1 << code);
  endfunction
endpackage

// File: rtl/slt_entry.sv
`timescale 1ns/1ps
module slt_entry
  import slt_pkg::*;
#(
  parameter int unsigned TAG_W  = 9,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic              kill_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic [TAG_W-1:0]  chk_tag_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [TAG_W-1:0]  rinv_tag_i,
  input  logic [ADDR_W-1:0] ainv_addr_i,
  input  logic [SZ_W-1:0]   ainv_size_i,
  output logic              vld_o,
  output logic              chk_hit_o,
  output logic              wr_hit_o,
  output logic              rinv_hit_o,
  output logic              ainv_hit_o
);
  localparam int unsigned EXT_W = ADDR_W + 1;

  logic              vld_q;
  logic [TAG_W-1:0]  tag_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SZ_W-1:0]   size_q;
  logic [EXT_W-1:0]  e_lo, e_hi, r_lo, r_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      tag_q  <= '0;
      addr_q <= '0;
      size_q <= '0;
    end else if (ld_i) begin
      // write lands after any same-cycle invalidate
      vld_q  <= 1'b1;
      tag_q  <= tag_i;
      addr_q <= addr_i;
      size_q <= size_i;
    end else if (kill_i) begin
      vld_q  <= 1'b0;
    end
  end

  // extra bit keeps range ends from wrapping
  assign e_lo = {1'b0, addr_q};
  assign e_hi = e_lo + EXT_W'(sz_bytes(size_q));
  assign r_lo = {1'b0, ainv_addr_i};
  assign r_hi = r_lo + EXT_W'(sz_bytes(ainv_size_i));

  assign vld_o      = vld_q;
  assign chk_hit_o  = vld_q && (tag_q == chk_tag_i);
  assign wr_hit_o   = vld_q && (tag_q == wr_tag_i);
  assign rinv_hit_o = vld_q && (tag_q == rinv_tag_i);
  assign ainv_hit_o = vld_q && (e_lo < r_hi) && (r_lo < e_hi);

  // R10
  ld_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && kill_i) |=> (vld_q && tag_q == $past(tag_i)));
endmodule

// File: rtl/slt_victim.sv
`timescale 1ns/1ps
module slt_victim #(
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic [DEPTH-1:0] live_i,
  input  logic [DEPTH-1:0] match_i,
  output logic [DEPTH-1:0] tgt_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0] ptr_q;
  logic [DEPTH-1:0] free_oh, rr_oh;
  logic             found, repl;

  always_comb begin
    free_oh = '0;
    found   = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!live_i[i] && !found) begin
        free_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign rr_oh = DEPTH'(1) << ptr_q;
  assign repl  = alloc_i && (match_i == '0) && !found;
  assign tgt_o = (match_i != '0) ? match_i : (found ? free_oh : rr_oh);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ptr_q <= '0;
    else if (repl) ptr_q <= (ptr_q == PTR_W'(DEPTH-1)) ? '0 : ptr_q + 1'b1;
  end

  // R3
  tag_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_i));
  // R4
  tgt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> $onehot(tgt_o));
endmodule

// File: rtl/spec_load_table.sv
`timescale 1ns/1ps
module spec_load_table
  import slt_pkg::*;
#(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned RT_W    = 2,
  parameter int unsigned RN_W    = 7,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DELTA_W = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_valid_i,
  input  logic [1:0]         wr_ldtype_i,
  input  logic [RT_W-1:0]    wr_rtype_i,
  input  logic [RN_W-1:0]    wr_rnum_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [2:0]         wr_size_i,
  input  logic [RT_W-1:0]    chk_rtype_i,
  input  logic [RN_W-1:0]    chk_rnum_i,
  output logic               chk_hit_o,
  input  logic               ainv_valid_i,
  input  logic [ADDR_W-1:0]  ainv_addr_i,
  input  logic [2:0]         ainv_size_i,
  input  logic               rinv_valid_i,
  input  logic [RT_W-1:0]    rinv_rtype_i,
  input  logic [RN_W-1:0]    rinv_rnum_i,
  input  logic               flush_i,
  input  logic               frame_valid_i,
  input  logic [DELTA_W-1:0] frame_dbof_i,
  input  logic [DELTA_W-1:0] frame_dsof_i
);
  localparam int unsigned TAG_W = RT_W + RN_W;

  logic [TAG_W-1:0] wr_tag, chk_tag, rinv_tag;
  logic [DEPTH-1:0] vld, chk_hit, wr_hit, rinv_hit, ainv_hit;
  logic [DEPTH-1:0] kill, live, hitv, tgt, ld;
  logic             wr_en, frame_kill;

  assign wr_tag   = {wr_rtype_i, wr_rnum_i};
  assign chk_tag  = {chk_rtype_i, chk_rnum_i};
  assign rinv_tag = {rinv_rtype_i, rinv_rnum_i};

  // clearing check loads never allocate
  assign wr_en = wr_valid_i &&
                 ((wr_ldtype_i == LD_ADV) || (wr_ldtype_i == LD_CHK_NC));
  // conservative tag management: any frame move drops everything
  assign frame_kill = frame_valid_i &&
                      ((frame_dbof_i != '0) || (frame_dsof_i != '0));

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign kill[g] = flush_i || frame_kill ||
                     (ainv_valid_i && ainv_hit[g]) ||
                     (rinv_valid_i && rinv_hit[g]);
    assign ld[g]   = wr_en && tgt[g];

    slt_entry #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ld_i        (ld[g]),
      .kill_i      (kill[g]),
      .tag_i       (wr_tag),
      .addr_i      (wr_addr_i),
      .size_i      (wr_size_i),
      .chk_tag_i   (chk_tag),
      .wr_tag_i    (wr_tag),
      .rinv_tag_i  (rinv_tag),
      .ainv_addr_i (ainv_addr_i),
      .ainv_size_i (ainv_size_i),
      .vld_o       (vld[g]),
      .chk_hit_o   (chk_hit[g]),
      .wr_hit_o    (wr_hit[g]),
      .rinv_hit_o  (rinv_hit[g]),
      .ainv_hit_o  (ainv_hit[g])
    );
  end

  assign live = vld & ~kill;
  assign hitv = wr_hit & ~kill;

  slt_victim #(.DEPTH(DEPTH)) u_vic (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alloc_i (wr_en),
    .live_i  (live),
    .match_i (hitv),
    .tgt_o   (tgt)
  );

  assign chk_hit_o = |chk_hit;

  // R2
  chk_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chk_hit));
  // R3
  wr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> ((vld & $past(tgt)) != '0));
  // R7
  rinv_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rinv_valid_i && !wr_en) |=> ((vld & $past(rinv_hit)) == '0));
  // R8
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !wr_en) |=> (vld == '0));
  // R9
  frame_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_kill && !wr_en) |=> (vld == '0));
endmodule

// File: tb/spec_load_table_tb_top.sv
`timescale 1ns/1ps
module spec_load_table_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 0;
  logic [1:0]  wr_ldtype_i = 0;
  logic [1:0]  wr_rtype_i = 0;
  logic [6:0]  wr_rnum_i = 0;
  logic [15:0] wr_addr_i = 0;
  logic [2:0]  wr_size_i = 0;
  logic [1:0]  chk_rtype_i = 0;
  logic [6:0]  chk_rnum_i = 0;
  logic        chk_hit_o;
  logic        ainv_valid_i = 0;
  logic [15:0] ainv_addr_i = 0;
  logic [2:0]  ainv_size_i = 0;
  logic        rinv_valid_i = 0;
  logic [1:0]  rinv_rtype_i = 0;
  logic [6:0]  rinv_rnum_i = 0;
  logic        flush_i = 0;
  logic        frame_valid_i = 0;
  logic [6:0]  frame_dbof_i = 0;
  logic [6:0]  frame_dsof_i = 0;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  spec_load_table dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_valid_i(wr_valid_i), .wr_ldtype_i(wr_ldtype_i), .wr_rtype_i(wr_rtype_i),
    .wr_rnum_i(wr_rnum_i), .wr_addr_i(wr_addr_i), .wr_size_i(wr_size_i),
    .chk_rtype_i(chk_rtype_i), .chk_rnum_i(chk_rnum_i), .chk_hit_o(chk_hit_o),
    .ainv_valid_i(ainv_valid_i), .ainv_addr_i(ainv_addr_i), .ainv_size_i(ainv_size_i),
    .rinv_valid_i(rinv_valid_i), .rinv_rtype_i(rinv_rtype_i), .rinv_rnum_i(rinv_rnum_i),
    .flush_i(flush_i), .frame_valid_i(frame_valid_i),
    .frame_dbof_i(frame_dbof_i), .frame_dsof_i(frame_dsof_i)
  );

  // op: 0 idle, 1 write, 2 address invalidate, 3 register invalidate, 4 flush
  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  ldt;
    logic [1:0]  rt;
    logic [6:0]  rn;
    logic [15:0] addr;
    logic [2:0]  sz;
    logic [1:0]  crt;
    logic [6:0]  crn;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  // exp is the hit seen during the vector's own cycle, before its command applies
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd0, 2'd0, 7'd0, 16'h0000, 3'd0, 2'd0, 7'd5, 1'b0, 4'd1},  // R1
    '{3'd1, 2'd0, 2'd0, 7'd5, 16'h0100, 3'd2, 2'd0, 7'd5, 1'b0, 4'd11}, // R11
    '{3'd0, 2'd0, 2'd0, 7'd0, 16'h0000, 3'd0, 2'd0, 7'd5, 1'b1, 4'd2},  // R2
    '{3'd0, 2'd0, 2'd0, 7'd0, 16'h0000, 3'd0, 2'd1, 7'd5, 1'b0, 4'd2},  // R2 type differs
    '{3'd1, 2'd1, 2'd0, 7'd5, 16'h0200, 3'd3, 2'd0, 7'd5, 1'b1, 4'd3},  // R3 update
    '{3'd2, 2'd0, 2'd0, 7'd0, 16'h0100, 3'd2, 2'd0, 7'd5, 1'b1, 4'd3},
    '{3'd0, 2'd0, 2'd0, 7'd0, 16'h0000, 3'd0, 2'd0, 7'd5, 1'b1, 4'd3},  // R3 old range gone
    '{3'd2, 2'd0, 2'd0, 7'd0, 16'h01F8, 3'd3, 2'd0, 7'd5, 1'b1, 4'd6},
    '{3'd0, 2'd0, 2'd0, 7'd0, 16'h0000, 3'd0, 2'd0, 7'd5, 1'b1, 4'd6},  // R6 touching below
    '{3'd2, 2'd0, 2'd0, 7'd0, 16'h0207, 3'd0, 2'd0, 7'd5, 1'b1, 4'd6},
    '{3'd0, 2'd0, 2'd0, 7'd0, 16'h0000, 3'd0, 2'd0, 7'd5, 1'b0, 4'd6},  // R6 last byte
    '{3'd1, 2'd2, 2'd0, 7'd6, 16'h0300, 3'd0, 2'd0, 7'd6, 1'b0, 4'd5},
    '{3'd0, 2'd0, 2'd0, 7'd0, 16'h0000, 3'd0, 2'd0, 7'd6, 1'b0, 4'd5},  // R5 type 2
    '{3'd1, 2'd3, 2'd0, 7'd6, 16'h0300, 3'd0, 2'd0, 7'd6, 1'b0, 4'd5},
    '{3'd0, 2'd0, 2'd0, 7'd0, 16'h0000, 3'd0, 2'd0, 7'd6, 1'b0, 4'd5},  // R5 type 3
    '{3'd1, 2'd0, 2'd0, 7'd6, 16'h0300, 3'd0, 2'd0, 7'd6, 1'b0, 4'd2},
    '{3'd1, 2'd0, 2'd1, 7'd5, 16'h0400, 3'd4, 2'd0, 7'd6, 1'b1, 4'd2},
    '{3'd3, 2'd0, 2'd1, 7'd5, 16'h0000, 3'd0, 2'd1, 7'd5, 1'b1, 4'd7},
    '{3'd0, 2'd0, 2'd0, 7'd0, 16'h0000, 3'd0, 2'd1, 7'd5, 1'b0, 4'd7},  // R7 target gone
    '{3'd0, 2'd0, 2'd0, 7'd0, 16'h0000, 3'd0, 2'd0, 7'd6, 1'b1, 4'd7},  // R7 other kept
    '{3'd4, 2'd0, 2'd0, 7'd0, 16'h0000, 3'd0, 2'd0, 7'd6, 1'b1, 4'd8},
    '{3'd0, 2'd0, 2'd0, 7'd0, 16'h0000, 3'd0, 2'd0, 7'd6, 1'b0, 4'd8},  // R8
    '{3'd1, 2'd0, 2'd0, 7'd5, 16'h0500, 3'd0, 2'd0, 7'd5, 1'b0, 4'd6},
    '{3'd2, 2'd0, 2'd0, 7'd0, 16'h04F0, 3'd7, 2'd0, 7'd5, 1'b1, 4'd6},
    '{3'd0, 2'd0, 2'd0, 7'd0, 16'h0000, 3'd0, 2'd0, 7'd5, 1'b1, 4'd6},  // R6 code 7 is 16 bytes
    '{3'd2, 2'd0, 2'd0, 7'd0, 16'h04F1, 3'd7, 2'd0, 7'd5, 1'b1, 4'd6},
    '{3'd0, 2'd0, 2'd0, 7'd0, 16'h0000, 3'd0, 2'd0, 7'd5, 1'b0, 4'd6}   // R6
  };

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: chk_hit_o=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_valid_i = 0; ainv_valid_i = 0; rinv_valid_i = 0;
    flush_i = 0; frame_valid_i = 0; frame_dbof_i = 0; frame_dsof_i = 0;
  endtask

  task automatic wr(input logic [6:0] rn, input logic [15:0] a);
    wr_valid_i = 1; wr_ldtype_i = 0; wr_rtype_i = 0; wr_rnum_i = rn;
    wr_addr_i = a; wr_size_i = 0;
  endtask

  // lookup in a fresh idle cycle
  task automatic look(input logic [6:0] rn, input logic exp, input string req);
    chk_rtype_i = 0; chk_rnum_i = rn;
    #1 check(req, chk_hit_o, exp);
  endtask

  task automatic step();
    @(negedge clk); idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: expired, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    look(7'd5, 1'b0, "R1");
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle();
      case (VECS[i].op)
        3'd1: begin
          wr_valid_i = 1; wr_ldtype_i = VECS[i].ldt; wr_rtype_i = VECS[i].rt;
          wr_rnum_i = VECS[i].rn; wr_addr_i = VECS[i].addr; wr_size_i = VECS[i].sz;
        end
        3'd2: begin
          ainv_valid_i = 1; ainv_addr_i = VECS[i].addr; ainv_size_i = VECS[i].sz;
        end
        3'd3: begin
          rinv_valid_i = 1; rinv_rtype_i = VECS[i].rt; rinv_rnum_i = VECS[i].rn;
        end
        3'd4: flush_i = 1;
        default: ;
      endcase
      chk_rtype_i = VECS[i].crt; chk_rnum_i = VECS[i].crn;
      #1 check($sformatf("R%0d vec %0d", VECS[i].req, i), chk_hit_o, VECS[i].exp);
    end
    step();

    // R4: fill four entries, then two replacements walk entries 0 and 1
    for (int k = 0; k < 4; k++) begin
      wr(7'(10 + k), 16'(16'h1000 + 16 * k)); step();
    end
    wr(7'd14, 16'h2000); step();
    look(7'd10, 1'b0, "R4 first victim"); look(7'd11, 1'b1, "R4"); look(7'd14, 1'b1, "R4");
    wr(7'd15, 16'h2100); step();
    look(7'd11, 1'b0, "R4 second victim"); look(7'd12, 1'b1, "R4");
    look(7'd13, 1'b1, "R4"); look(7'd15, 1'b1, "R4");
    wr(7'd12, 16'h3000); step();
    look(7'd13, 1'b1, "R3 rewrite on full table keeps others");
    look(7'd14, 1'b1, "R3");

    // R1: reset mid-run empties the table
    rst_ni = 1'b0;
    look(7'd15, 1'b0, "R1 during reset");
    step(); rst_ni = 1'b1;
    look(7'd12, 1'b0, "R1 after reset");

    // R9
    wr(7'd20, 16'h0600); step();
    frame_valid_i = 1; step();
    look(7'd20, 1'b1, "R9 zero deltas");
    frame_valid_i = 1; frame_dsof_i = 7'd2; step();
    look(7'd20, 1'b0, "R9 size delta");
    wr(7'd20, 16'h0600); step();
    frame_valid_i = 1; frame_dbof_i = 7'd3; step();
    look(7'd20, 1'b0, "R9 bottom delta");

    // R10: invalidate and write in one cycle
    wr(7'd30, 16'h0600); step();
    wr(7'd30, 16'h0700); rinv_valid_i = 1; rinv_rtype_i = 0; rinv_rnum_i = 7'd30; step();
    look(7'd30, 1'b1, "R10 reg invalidate plus write");
    wr(7'd31, 16'h0800); step();
    wr(7'd32, 16'h0900); flush_i = 1; step();
    look(7'd32, 1'b1, "R10 flush plus write");
    look(7'd31, 1'b0, "R10 flush still clears others");
    wr(7'd32, 16'h0A00); ainv_valid_i = 1; ainv_addr_i = 16'h0A00; ainv_size_i = 0; step();
    look(7'd32, 1'b1, "R10 address invalidate plus write");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule